// File: doc/BRIEF.md
# Strobe-Driven FIFO with Rewind and Half-Full Flag

This block is a first-in first-out buffer of 9-bit words whose depth is a power-of-two parameter (256, 512 or 1024). It is driven by active-low strobes. Each operation starts on the falling edge of its strobe, and the clock samples every strobe. The buffer keeps no addresses at its edge. A write pointer and a read pointer move around a ring, and an occupancy counter drives three active-low flags: empty, full and half-full. Writes are refused while the buffer is full. Reads are refused while it is empty.

A read places the oldest word on `dout`. `dout_vld` marks that word as valid until the read strobe goes high again. Pulling `rewind_n` low sends the read pointer back to location 0 and leaves the write pointer where it is, so the stored data can be read out again. The control is a three-state machine:
- `ST_CLEAR` is entered by reset and lasts for the first clock after reset is released.
- `ST_ACTIVE` is the normal state. In it, strobes are acted on.
- `ST_REWIND` lasts while the rewind input is held low.

The transitions are:
- CLEAR→ACTIVE always.
- ACTIVE→REWIND when `rewind_n` is low.
- REWIND→REWIND while `rewind_n` stays low.
- REWIND→ACTIVE when `rewind_n` is high.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, both pointers and the occupancy are zero and strobe edges are ignored. The flags read `empty_n`=0, `full_n`=1 and `half_n`=1, and `dout_vld`=0.
- R2: A write is accepted only in the clock cycle where `wr_n` is first sampled low after being high, and only if the buffer is not full. Holding `wr_n` low for several cycles stores one word. Words go to consecutive locations.
- R3: A read is accepted on the first low sample of `rd_n`, and only if the buffer is not empty. One cycle later, `dout` holds the oldest unread word and `dout_vld`=1. `dout_vld` returns to 0 one cycle after `rd_n` is sampled high again.
- R4: After DEPTH accepted writes with no reads, `full_n`=0. Further write strobes store nothing and leave the occupancy unchanged.
- R5: The read that removes the last word completes normally and drives `empty_n` to 0. Read strobes while the buffer is empty leave `dout_vld` at 0 and change nothing.
- R6: `half_n` goes to 0 in the cycle after an accepted write that raises occupancy above DEPTH/2. It returns to 1 only in the cycle after a rising edge of `rd_n` at which occupancy is at most DEPTH/2. A read falling edge alone never releases it.
- R7: A low level on `rewind_n` moves the read pointer to location 0 and sets the occupancy to the write-pointer index. It recomputes `half_n` as occupancy above DEPTH/2, clears `dout_vld`, and ignores strobe edges until `rewind_n` is high again. Replay is correct when fewer than DEPTH writes have occurred since reset.
- R8: When a write and a read are both accepted in the same cycle, the occupancy and the flags are unchanged.
- R9: `full_n` returns to 1 one cycle after a read is accepted. `empty_n` returns to 1 one cycle after a write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rewind_n | input | 1 | Active-low read-pointer rewind |
| din | input | 9 | Write data |
| dout | output | 9 | Read data |
| dout_vld | output | 1 | Read data valid while the read strobe is held |
| empty_n | output | 1 | Low when nothing is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low while above half occupancy (set/release rules of R6) |

## Verification
The buffer is tested with several patterns, each aimed at a different fault:
- Short write-then-read bursts check ordering and the edge-only start of operations.
- A held-low write strobe checks that a level is not treated as an edge.
- A full fill with a write attempt beyond capacity, followed by a complete drain, checks overflow blocking. If a refused word were stored, it would appear in the drained data.
- Passing through DEPTH/2 in both directions separates the write-set and read-rise-release behaviour of the half-full flag from a plain occupancy compare.
- A rewind after partial reads, with a read strobe pulsed during the rewind, checks replay from location 0, the recomputed half-full state and the ignored edge.
- Paired write and read strobes check that occupancy is held constant.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_REWIND = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/sfifo_edge.sv
module sfifo_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b1;
            else        prev_q[i] <= strobe_n[i];
        end
        assign fall[i] = prev_q[i] & ~strobe_n[i];
        assign rise[i] = ~prev_q[i] & strobe_n[i];
    end
endmodule

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
    parameter int W     = 9,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rewind_n,
    input  logic          wr_fall,
    input  logic          rd_fall,
    input  logic          rd_rise,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          rd_take,
    output logic          dout_vld,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

    ctrl_state_e   state_q, state_d;
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          half_q, vld_q;
    logic          is_full, is_empty, op_ok, rewind_now, wr_acc, rd_acc;

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_CLEAR:  state_d = ST_ACTIVE;
            ST_ACTIVE: state_d = rewind_n ? ST_ACTIVE : ST_REWIND;
            ST_REWIND: state_d = rewind_n ? ST_ACTIVE : ST_REWIND;
            default:   state_d = ST_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    assign is_full    = (cnt_q == CNT_FULL);
    assign is_empty   = (cnt_q == '0);
    assign op_ok      = (state_q == ST_ACTIVE) && rewind_n;
    assign rewind_now = (state_q == ST_ACTIVE) && !rewind_n;
    assign wr_acc     = op_ok && wr_fall && !is_full;
    assign rd_acc     = op_ok && rd_fall && !is_empty;

    always_comb begin
        unique case ({wr_acc, rd_acc})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    // pointer, occupancy and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            half_q <= 1'b0;
            vld_q  <= 1'b0;
        end else if (rewind_now) begin
            rptr_q <= '0;
            cnt_q  <= {1'b0, wptr_q};
            half_q <= ({1'b0, wptr_q} > CNT_HALF);
            vld_q  <= 1'b0;
        end else begin
            if (wr_acc) wptr_q <= wptr_q + 1'b1;
            if (rd_acc) rptr_q <= rptr_q + 1'b1;
            cnt_q <= cnt_d;
            if (wr_acc && (cnt_d > CNT_HALF))
                half_q <= 1'b1;
            else if (op_ok && rd_rise && (cnt_d <= CNT_HALF))
                half_q <= 1'b0;
            if (rd_acc)       vld_q <= 1'b1;
            else if (rd_rise) vld_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        we       = wr_acc;
        waddr    = wptr_q;
        raddr    = rptr_q;
        rd_take  = rd_acc;
        dout_vld = vld_q;
        empty_n  = !is_empty;
        full_n   = !is_full;
        half_n   = !half_q;
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);

    // R4
    full_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && wr_fall && op_ok) |=> $stable(wptr_q));

    // R5
    empty_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && rd_fall && op_ok) |=> $stable(rptr_q));

    // R7
    rewind_rptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_now |=> (rptr_q == '0) && (cnt_q == {1'b0, $past(wptr_q)}));

    // R8
    pair_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && rd_acc) |=> $stable(cnt_q));

    // R1
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_n || full_n);
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rewind_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_vld,
    output logic             empty_n,
    output logic             full_n,
    output logic             half_n
);
    logic [1:0]       fall, rise;
    logic             we, rd_take;
    logic [AW-1:0]    waddr, raddr;
    logic [WIDTH-1:0] rdata;

    sfifo_edge #(.N(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n ({rd_n, wr_n}),
        .fall     (fall),
        .rise     (rise)
    );

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rewind_n (rewind_n),
        .wr_fall  (fall[0]),
        .rd_fall  (fall[1]),
        .rd_rise  (rise[1]),
        .we       (we),
        .waddr    (waddr),
        .raddr    (raddr),
        .rd_take  (rd_take),
        .dout_vld (dout_vld),
        .empty_n  (empty_n),
        .full_n   (full_n),
        .half_n   (half_n)
    );

    sfifo_ram #(.W(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout <= '0;
        else if (rd_take) dout <= rdata;
    end
endmodule

// File: tb/sim_strobe_fifo.sv
`timescale 1ns/1ps
module sim_strobe_fifo;
    localparam int DEPTH = 256;
    localparam int H     = DEPTH / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, rewind_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_vld, empty_n, full_n, half_n;

    int nchk = 0, nerr = 0;
    int mcnt = 0;
    bit mhalf = 0;
    bit done = 0;
    logic [8:0] hist[$];
    logic [8:0] exp_q[$];
    bit vld_seen = 0;

    always #2.5 clk = ~clk;

    strobe_fifo #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
        .rewind_n(rewind_n), .din(din), .dout(dout), .dout_vld(dout_vld),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    task automatic check(input string tag, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic chk_flags(input string tag);
        check({tag, " flags"}, {empty_n, full_n, half_n},
              {mcnt != 0, mcnt != DEPTH, !mhalf});
    endtask

    // monitor: compares each newly valid read word with the scoreboard (R3)
    always @(negedge clk) begin
        if (dout_vld && !vld_seen) begin
            if (exp_q.size() == 0) check("R3 unexpected read data", 1, 0);
            else check("R3 read order", dout, exp_q.pop_front());
        end
        vld_seen = dout_vld;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        mcnt = 0; mhalf = 0; hist.delete(); exp_q.delete();
        repeat (2) @(negedge clk);
        wr_n = 1'b0;          // edge during reset must be ignored (R1)
        @(negedge clk);
        wr_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [8:0] v, input int hold, input string tag);
        @(negedge clk);
        din = v; wr_n = 1'b0;
        if (mcnt < DEPTH) begin
            hist.push_back(v); exp_q.push_back(v); mcnt++;
            if (mcnt > H) mhalf = 1;
        end
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        chk_flags(tag);
    endtask

    task automatic do_read(input string tag);
        bit had;
        had = (mcnt > 0);
        @(negedge clk);
        rd_n = 1'b0;
        if (had) mcnt--;
        @(negedge clk);
        if (!had) check("R5 read while empty", dout_vld, 0);
        rd_n = 1'b1;
        @(negedge clk);
        if (mcnt <= H) mhalf = 0;
        check("R3 valid drops", dout_vld, 0);
        chk_flags(tag);
    endtask

    task automatic do_both(input logic [8:0] v);
        bit wok, rok;
        wok = (mcnt < DEPTH);
        rok = (mcnt > 0);
        @(negedge clk);
        din = v; wr_n = 1'b0; rd_n = 1'b0;
        if (wok) begin hist.push_back(v); exp_q.push_back(v); end
        mcnt = mcnt + int'(wok) - int'(rok);
        if (wok && mcnt > H) mhalf = 1;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        if (mcnt <= H) mhalf = 0;
        chk_flags("R8");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk_flags("R1");
        check("R1 dout_vld", dout_vld, 0);

        // R2/R3/R9 short burst
        for (int i = 0; i < 5; i++) do_write(9'(16 + i), 1, "R9 R2");
        do_read("R3");
        do_read("R3");
        for (int i = 0; i < 3; i++) do_read("R5");
        do_read("R5");   // read while empty is ignored

        // R2 held-low strobe stores one word
        do_write(9'h155, 4, "R2 hold");
        do_read("R2 hold");
        do_read("R2 single");

        // R4/R6/R9 full fill then drain
        do_reset();
        for (int i = 0; i < DEPTH; i++) do_write(9'(i * 3 + 1), 1, "R6 R4");
        do_write(9'h1AA, 1, "R4 overflow");
        do_read("R9 full release");
        while (mcnt > 100) do_read("R6");
        for (int i = 0; i < 3; i++) do_both(9'(300 + i));
        while (mcnt > 0) do_read("R6 drain");

        // R7 rewind after partial reads, with a half-full change
        do_reset();
        for (int i = 0; i < 150; i++) do_write(9'(i + 7), 1, "R7 load");
        for (int i = 0; i < 30; i++) do_read("R7 partial");
        @(negedge clk);
        rewind_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b0;                 // ignored during rewind
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        rewind_n = 1'b1;
        exp_q = hist;
        mcnt = hist.size();
        mhalf = (mcnt > H);
        @(negedge clk);
        check("R7 valid cleared", dout_vld, 0);
        chk_flags("R7 rewind");
        while (mcnt > 0) do_read("R7 replay");
        check("R7 all replayed", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule